// File: doc/BRIEF.md
# Console Serial Port Register Front-End

This block is the byte-wide register face of a console serial port. It presents a set of small register offsets to a processor bus, so that an operating-system probe of an 8250-style port finds the answers it expects. A single-entry holding buffer takes in received characters. A write to the data offset hands a byte to the transmit path as a one-cycle strobe. A transmit-interrupt pending flag is set from outside and is cleared by a command code written over the bus. Baud generation, bit serialization, FIFOs and modem lines are not part of this block.

The block also supports a two-step interrupt-source query. The host first writes an arming command to the command offset. Its next read of the status offset then returns an interrupt-source code in place of the usual line-status byte. The armed state lasts for that one read only.

The receive input is a valid/ready stream with these back-pressure rules. The source raises `rx_valid` and holds `rx_data` steady until it sees `rx_ready` high at a clock edge. `rx_ready` is high only during a status read that finds the holding buffer empty, and a character moves on the edge where both signals are high. The transmit output has no back-pressure: `tx_valid` is a single-cycle strobe, and the consumer must take `tx_data` in that cycle. The bus strobes `bus_rd` and `bus_wr` are never high in the same cycle. Read data is combinational and valid in the cycle that `bus_rd` is high.

Top module: `con_uart_regs`

## Requirements
- R1: After reset, `rx_pend`, `txint_pend`, `tx_valid` and `ack_err` are 0, the status offset 5 reads 0x64, and the interrupt-enable offset 1 reads 0.
- R2: When not armed, a read of offset 5 returns 0x64 (bits 2, 5 and 6 set). Bit 0 is also set when a character is held or is captured during that same read.
- R3: `rx_ready` is 1 only while offset 5 is being read and the buffer is empty. On that edge, if `rx_valid` is 1, the character is captured and `rx_pend` becomes 1 in the next cycle.
- R4: A read of offset 0 returns the held character and empties the buffer, so `rx_pend` is 0 in the next cycle.
- R5: A write to offset 0 makes `tx_valid` 1 for the next cycle only, with `tx_data` equal to the written byte.
- R6: A write to offset 1 stores the interrupt-enable byte. A read of offset 1 returns 0x0F only when the stored value is exactly 0x0F, and returns 0 otherwise.
- R7: Offset 2 and any unused offset (4, 6, 7) read 0. A write to offset 4 changes no readable state.
- R8: After 0x03 is written to offset 3, the next read of offset 5 returns 0x10 if a transmit interrupt is pending, otherwise 0x20 if a character is held or captured in that read, otherwise 0x00. The read after that is a normal status read.
- R9: `txint_set` makes `txint_pend` 1 in the next cycle. Writing 0x28 to offset 3 clears it. If both happen in the same cycle, the set wins.
- R10: Writing 0x28 to offset 3 while `txint_pend` is 0 pulses `ack_err` for the next cycle only. The pending flag is not set by this write.
- R11: Any byte written to offset 3 replaces the stored command. Writing a value other than 0x03 after 0x03 cancels the armed status read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register offset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational, 0 when not reading) |
| rx_valid | input | 1 | Received character offered |
| rx_data | input | 8 | Received character |
| rx_ready | output | 1 | Character accepted on this edge if valid |
| tx_valid | output | 1 | One-cycle transmit strobe |
| tx_data | output | 8 | Transmitted byte |
| txint_set | input | 1 | Raise the transmit-interrupt pending flag |
| txint_pend | output | 1 | Transmit-interrupt pending |
| rx_pend | output | 1 | A received character is held |
| ack_err | output | 1 | One-cycle pulse on an acknowledge with nothing pending |

## Verification
The interrupt-enable echo and the transmit path are each swept over all 256 byte values. The sweep separates the single echoed pattern from its near neighbours, and it shows that every bit reaches `tx_data`. The armed status read is tried under all four combinations of transmit and receive pending, plus a character that arrives during the armed read itself. Together these separate the priority order from the plain status byte and show that the armed state lasts one read. Acknowledges are issued with the flag pending, with it clear, and in the same cycle as a set, which separates a clean clear, an error pulse and set priority.

// File: rtl/con_uart_pkg.sv
package con_uart_pkg;
  localparam int unsigned AW = 3;
  localparam int unsigned DW = 8;

  localparam logic [AW-1:0] OFS_DATA  = 3'd0;
  localparam logic [AW-1:0] OFS_IEN   = 3'd1;
  localparam logic [AW-1:0] OFS_ID    = 3'd2;
  localparam logic [AW-1:0] OFS_CMD   = 3'd3;
  localparam logic [AW-1:0] OFS_MODEM = 3'd4;
  localparam logic [AW-1:0] OFS_STAT  = 3'd5;

  localparam logic [DW-1:0] CMD_ARM    = 8'h03;
  localparam logic [DW-1:0] CMD_TXACK  = 8'h28;
  localparam logic [DW-1:0] STAT_BASE  = 8'h64;
  localparam logic [DW-1:0] IEN_PROBE  = 8'h0F;
  localparam logic [DW-1:0] SRC_TX     = 8'h10;
  localparam logic [DW-1:0] SRC_RX     = 8'h20;

  // interrupt state: tx in bit 0, rx in bit 1
  typedef struct packed {
    logic rx;
    logic tx;
  } irq_state_t;
endpackage

// File: rtl/con_rx_hold.sv
module con_rx_hold
  import con_uart_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stat_rd,
  input  logic          data_rd,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  output logic          held,
  output logic          pend_now,
  output logic [DW-1:0] hold_data
);
  logic          vld_q;
  logic [DW-1:0] chr_q;
  logic          take;

  assign in_ready  = stat_rd & ~vld_q;
  assign take      = in_valid & in_ready;
  assign pend_now  = vld_q | take;
  assign held      = vld_q;
  assign hold_data = chr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      chr_q <= '0;
    end else if (take) begin
      vld_q <= 1'b1;
      chr_q <= in_data;
    end else if (data_rd) begin
      vld_q <= 1'b0;
    end
  end

  // R3
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (held && hold_data == $past(in_data)));
  // R4
  drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !stat_rd) |=> !held);
endmodule

// File: rtl/con_cmd_ctl.sv
module con_cmd_ctl
  import con_uart_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_wr,
  input  logic [DW-1:0] wdata,
  input  logic          stat_rd,
  input  logic          irq_set,
  output logic          armed,
  output logic          tx_pend,
  output logic          ack_err
);
  logic [DW-1:0] cmd_q;
  logic          ack;

  assign armed = (cmd_q == CMD_ARM);
  assign ack   = cmd_wr && (wdata == CMD_TXACK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      tx_pend <= 1'b0;
      ack_err <= 1'b0;
    end else begin
      if (cmd_wr)
        cmd_q <= wdata;
      else if (stat_rd && armed)
        cmd_q <= '0;
      if (irq_set)
        tx_pend <= 1'b1;
      else if (ack)
        tx_pend <= 1'b0;
      ack_err <= ack && !tx_pend;
    end
  end

  // R8
  one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && armed && !cmd_wr) |=> !armed);
  // R9
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && wdata == CMD_TXACK && !irq_set) |=> !tx_pend);
  // R10
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_err |-> (!tx_pend || $past(irq_set)));
endmodule

// File: rtl/con_rd_mux.sv
module con_rd_mux
  import con_uart_pkg::*;
(
  input  logic          rd,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] hold_data,
  input  logic [DW-1:0] ien,
  input  logic          armed,
  input  irq_state_t    irq,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] stat_val;

  always_comb begin
    if (armed)
      stat_val = irq.tx ? SRC_TX : (irq.rx ? SRC_RX : '0);
    else
      stat_val = STAT_BASE | {{(DW-1){1'b0}}, irq.rx};
  end

  always_comb begin
    rdata = '0;
    if (rd) begin
      unique case (addr)
        OFS_DATA: rdata = hold_data;
        OFS_IEN:  rdata = (ien == IEN_PROBE) ? IEN_PROBE : '0;
        OFS_STAT: rdata = stat_val;
        default:  rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/con_uart_regs.sv
module con_uart_regs
  import con_uart_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  output logic          rx_ready,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data,
  input  logic          txint_set,
  output logic          txint_pend,
  output logic          rx_pend,
  output logic          ack_err
);
  logic          stat_rd, data_rd, cmd_wr;
  logic          pend_now, armed;
  logic [DW-1:0] hold_data;
  logic [DW-1:0] ien_q;
  irq_state_t    irq;

  assign stat_rd = bus_rd && (bus_addr == OFS_STAT);
  assign data_rd = bus_rd && (bus_addr == OFS_DATA);
  assign cmd_wr  = bus_wr && (bus_addr == OFS_CMD);

  con_rx_hold u_rx (
    .clk(clk), .rst_n(rst_n), .stat_rd(stat_rd), .data_rd(data_rd),
    .in_valid(rx_valid), .in_data(rx_data), .in_ready(rx_ready),
    .held(rx_pend), .pend_now(pend_now), .hold_data(hold_data)
  );

  con_cmd_ctl u_cmd (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .wdata(bus_wdata),
    .stat_rd(stat_rd), .irq_set(txint_set), .armed(armed),
    .tx_pend(txint_pend), .ack_err(ack_err)
  );

  assign irq.tx = txint_pend;
  assign irq.rx = pend_now;

  con_rd_mux u_mux (
    .rd(bus_rd), .addr(bus_addr), .hold_data(hold_data), .ien(ien_q),
    .armed(armed), .irq(irq), .rdata(bus_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ien_q    <= '0;
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else begin
      if (bus_wr && bus_addr == OFS_IEN)
        ien_q <= bus_wdata;
      tx_valid <= bus_wr && (bus_addr == OFS_DATA);
      if (bus_wr && bus_addr == OFS_DATA)
        tx_data <= bus_wdata;
    end
  end

  // R5
  tx_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_DATA) |=> (tx_valid && tx_data == $past(bus_wdata)));
  // R5
  tx_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == OFS_DATA) |=> !tx_valid);
  // R3
  ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> (bus_rd && !rx_pend));
endmodule

// File: tb/sim_con_uart_regs.sv
module sim_con_uart_regs;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic       rx_ready, tx_valid, txint_pend, rx_pend, ack_err;
  logic [7:0] tx_data;
  logic       txint_set = 1'b0;
  int         n_run = 0, n_fail = 0;
  logic [7:0] rv;
  logic       rr;

  always #2.5 clk = ~clk;

  con_uart_regs u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .txint_set(txint_set),
    .txint_pend(txint_pend), .rx_pend(rx_pend), .ack_err(ack_err)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d, output logic rdy);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata; rdy = rx_ready;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pulse_set();
    @(negedge clk);
    txint_set = 1'b1;
    @(negedge clk);
    txint_set = 1'b0;
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    @(negedge clk);
    chk(!rx_pend && !txint_pend && !tx_valid && !ack_err, "R1", {rx_pend, txint_pend, tx_valid, ack_err}, 0);
    rd(3'd5, rv, rr); chk(rv == 8'h64, "R1", rv, 8'h64);
    rd(3'd1, rv, rr); chk(rv == 8'h00, "R1", rv, 0);

    // R6 sweep of interrupt-enable echo
    for (int v = 0; v < 256; v++) begin
      wr(3'd1, 8'(v));
      rd(3'd1, rv, rr);
      chk(rv == ((v == 15) ? 8'h0F : 8'h00), "R6", rv, (v == 15) ? 15 : 0);
    end

    // R7 constant offsets and ignored modem write
    rd(3'd2, rv, rr); chk(rv == 0, "R7", rv, 0);
    rd(3'd4, rv, rr); chk(rv == 0, "R7", rv, 0);
    rd(3'd6, rv, rr); chk(rv == 0, "R7", rv, 0);
    rd(3'd7, rv, rr); chk(rv == 0, "R7", rv, 0);
    wr(3'd4, 8'hFF);
    rd(3'd5, rv, rr); chk(rv == 8'h64, "R7", rv, 8'h64);
    rd(3'd1, rv, rr); chk(rv == 0, "R7", rv, 0);
    chk(!txint_pend && !rx_pend, "R7", {txint_pend, rx_pend}, 0);

    // R5 transmit sweep
    for (int v = 0; v < 256; v++) begin
      wr(3'd0, 8'(v));
      chk(tx_valid && tx_data == 8'(v), "R5", {tx_valid, tx_data}, 256 + v);
      @(negedge clk);
      chk(!tx_valid, "R5", tx_valid, 0);
    end

    // R3 / R2 receive handshake
    rx_valid = 1'b1; rx_data = 8'hA5;
    @(negedge clk); #1;
    chk(!rx_ready, "R3", rx_ready, 0);
    rd(3'd5, rv, rr);
    chk(rr && rv == 8'h65, "R3", {rr, rv}, 9'h165);
    rx_valid = 1'b0;
    chk(rx_pend, "R3", rx_pend, 1);
    rd(3'd5, rv, rr);
    chk(!rr && rv == 8'h65, "R2", {rr, rv}, 8'h65);
    // R4
    rd(3'd0, rv, rr); chk(rv == 8'hA5, "R4", rv, 8'hA5);
    chk(!rx_pend, "R4", rx_pend, 0);
    rd(3'd5, rv, rr); chk(rr && rv == 8'h64, "R2", {rr, rv}, 9'h164);

    // R8 armed read over all pending combinations
    for (int t = 0; t < 2; t++) begin
      for (int r = 0; r < 2; r++) begin
        if (t == 1) pulse_set();
        if (r == 1) begin
          rx_valid = 1'b1; rx_data = 8'(8'h40 + r);
          rd(3'd5, rv, rr);
          rx_valid = 1'b0;
        end
        wr(3'd3, 8'h03);
        rd(3'd5, rv, rr);
        chk(rv == ((t == 1) ? 8'h10 : (r == 1) ? 8'h20 : 8'h00), "R8", rv,
            (t == 1) ? 16 : (r == 1) ? 32 : 0);
        rd(3'd5, rv, rr);
        chk(rv == 8'(8'h64 + r), "R8", rv, 8'h64 + r);
        if (r == 1) rd(3'd0, rv, rr);
        if (t == 1) begin
          wr(3'd3, 8'h28);
          chk(!txint_pend && !ack_err, "R9", {txint_pend, ack_err}, 0);
        end
      end
    end
    // R8 character arriving during the armed read
    wr(3'd3, 8'h03);
    rx_valid = 1'b1; rx_data = 8'h5A;
    rd(3'd5, rv, rr);
    rx_valid = 1'b0;
    chk(rr && rv == 8'h20, "R8", {rr, rv}, 9'h120);
    rd(3'd0, rv, rr); chk(rv == 8'h5A, "R4", rv, 8'h5A);

    // R11 overwrite cancels arming
    wr(3'd3, 8'h03);
    wr(3'd3, 8'h12);
    rd(3'd5, rv, rr); chk(rv == 8'h64, "R11", rv, 8'h64);

    // R10 acknowledge with nothing pending
    wr(3'd3, 8'h28);
    chk(ack_err && !txint_pend, "R10", {ack_err, txint_pend}, 2);
    @(negedge clk);
    chk(!ack_err, "R10", ack_err, 0);

    // R9 set and acknowledge in the same cycle
    @(negedge clk);
    bus_addr = 3'd3; bus_wdata = 8'h28; bus_wr = 1'b1; txint_set = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; txint_set = 1'b0;
    chk(txint_pend, "R9", txint_pend, 1);
    chk(ack_err, "R10", ack_err, 1);
    wr(3'd3, 8'h28);
    chk(!txint_pend && !ack_err, "R9", {txint_pend, ack_err}, 0);

    finish_run();
  end
endmodule